// File: doc/BRIEF.md
# Bank-Group Column Command Timing Gate

This block sits between the command scheduler of a DRAM controller and the DRAM command bus. Each cycle it decides whether the column command (read or write) that the scheduler is presenting may go out. The device has sixteen banks in four bank groups of four banks each. Commands to different groups need only a short minimum spacing. Commands that land in the same group need a longer one.

The scheduler presents a request with a valid/ready handshake. The request carries a write flag and a 4-bit bank address. The gate raises ready only when both spacing rules allow the command. The accepted command appears on the command-bus outputs in the same cycle. Commands may issue on any cycle and are not tied to a slot grid.

For every accepted command the gate also times its completion. It raises a one-cycle read-data-valid pulse when a read's data is fully back at the controller. It raises a one-cycle write-done pulse when a write has finished. Several commands may be outstanding at once. Row commands (activate and precharge) are not column commands and pass straight through, untouched by the spacing logic. A legacy mode, for devices without bank groups, replaces both spacings with a single fixed spacing.

Top module: `bg_col_gate`

## Requirements
- R1: Synchronous active-high reset clears all spacing state and empties all completion state. In the first cycle after reset, reqReady is high, and the first request is accepted in the cycle it is presented.
- R2: After a command is accepted in cycle t, a command to a different bank group is accepted no earlier than cycle t + cfgShort. It is accepted in exactly that cycle when its group has no pending spacing.
- R3: The bank group is reqBank[3:2]. After a command to a group is accepted in cycle t, the next command to the same group is accepted no earlier than cycle t + cfgLong, even if other groups were used in between.
- R4: Whatever banks are targeted, no two column commands are accepted less than cfgShort cycles apart. A rotation over the four groups therefore issues one command every cfgShort cycles.
- R5: There is no slot grid. Once the spacing rules have been met, a request presented on any later cycle is accepted in that same cycle.
- R6: A read accepted in cycle t produces exactly one rdDataValid pulse, in cycle t + cfgCasRd + cfgBurst. Many reads may be in flight at once.
- R7: A write accepted in cycle t produces exactly one wrDone pulse, in cycle t + cfgBurst + cfgCasWr. A write pulse and a read pulse may occur in the same cycle.
- R8: A row command request (rowValid, rowCode) appears on rowFire and rowCodeOut in the same cycle, even while column commands are being held off.
- R9: While legacyMode is high, every pair of column commands is spaced by exactly PREFETCH / WORDS_PER_CLK cycles (4 by default), for any banks. cfgShort and cfgLong have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacyMode | input | 1 | Single-spacing mode for devices without bank groups |
| cfgShort | input | CW | Minimum spacing between commands to different groups (at least 1) |
| cfgLong | input | CW | Minimum spacing between commands to the same group (at least cfgShort) |
| cfgCasRd | input | CW | Read latency from issue to first data |
| cfgCasWr | input | CW | Write latency from issue to first data |
| cfgBurst | input | CW | Burst length in cycles |
| reqValid | input | 1 | Column request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | 4 | Bank address; the upper two bits are the group |
| reqReady | output | 1 | Request may issue this cycle |
| cmdFire | output | 1 | Column command is issued on the bus this cycle |
| cmdWrite | output | 1 | Issued command is a write |
| cmdBank | output | 4 | Bank of the issued command |
| rowValid | input | 1 | Row command request |
| rowCode | input | ROW_CODE_W | Row command code |
| rowFire | output | 1 | Row command is issued this cycle |
| rowCodeOut | output | ROW_CODE_W | Code of the issued row command |
| rdDataValid | output | 1 | A read's data is complete this cycle |
| wrDone | output | 1 | A write is complete this cycle |

## Verification
A read completion pulse and a write completion pulse can fall in the same cycle, because the two latencies are programmed independently. The bench provokes this by programming the read latency four cycles longer than the write latency. It issues a read and, four cycles later, a write to another group, so both completions are due in the same cycle. The scoreboard holds separate expected-cycle queues for reads and writes. It checks each pulse against the head of its own queue, and it checks that both pulses were seen together in that cycle.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic issue;      // a column command goes out this cycle
    logic isWrite;    // the command is a write
    logic useLegacy;  // single-spacing mode is active
  } bgc_strobe_t;

endpackage

// File: rtl/bgc_done_pipe.sv
module bgc_done_pipe #(
  parameter int DEPTH = 126,
  parameter int LAT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insert,
  input  logic [LAT_W-1:0] lat,
  output logic             pulse
);

  logic [DEPTH-1:0] slots;
  logic [DEPTH-1:0] newBit;

  // A token placed at index lat-1 reaches index 0 after lat-1 more shifts.
  // That is exactly lat cycles after the issue cycle.
  always_comb begin
    newBit = '0;
    if (insert) newBit = DEPTH'(1) << (lat - LAT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) slots <= '0;
    else     slots <= (slots >> 1) | newBit;
  end

  assign pulse = slots[0];

endmodule

// File: rtl/bgc_ctrl.sv
module bgc_ctrl
  import bgc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int BANK_W     = 4,
  parameter int GROUP_W    = 2
) (
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [BANK_W-1:0]     reqBank,
  input  logic                  legacyMode,
  input  logic                  globalIdle,
  input  logic [NUM_GROUPS-1:0] groupIdle,
  output logic                  reqReady,
  output logic [GROUP_W-1:0]    reqGroup,
  output bgc_strobe_t           strobe
);

  assign reqGroup = reqBank[BANK_W-1 -: GROUP_W];

  // The group check is skipped in legacy mode; only the global spacing applies then.
  always_comb begin
    reqReady         = globalIdle && (legacyMode || groupIdle[reqGroup]);
    strobe.issue     = reqValid && reqReady;
    strobe.isWrite   = reqWrite;
    strobe.useLegacy = legacyMode;
  end

endmodule

// File: rtl/bgc_datapath.sv
module bgc_datapath
  import bgc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 2,
  parameter int CW         = 6,
  parameter int LEGACY_CCD = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bgc_strobe_t           strobe,
  input  logic [GROUP_W-1:0]    issueGroup,
  input  logic [CW-1:0]         cfgShort,
  input  logic [CW-1:0]         cfgLong,
  input  logic [CW-1:0]         cfgCasRd,
  input  logic [CW-1:0]         cfgCasWr,
  input  logic [CW-1:0]         cfgBurst,
  output logic                  globalIdle,
  output logic [NUM_GROUPS-1:0] groupIdle,
  output logic                  rdDataValid,
  output logic                  wrDone
);

  localparam int LAT_W      = CW + 1;
  localparam int PIPE_DEPTH = 2 * ((1 << CW) - 1);

  logic [CW-1:0] globalCnt;
  logic [CW-1:0] globalLoad;

  assign globalLoad = strobe.useLegacy ? CW'(LEGACY_CCD - 1) : (cfgShort - CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                    globalCnt <= '0;
    else if (strobe.issue)      globalCnt <= globalLoad;
    else if (globalCnt != '0)   globalCnt <= globalCnt - CW'(1);
  end

  assign globalIdle = (globalCnt == '0);

  // One spacing counter per bank group.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [CW-1:0] grpCnt;
    logic          hit;
    assign hit = strobe.issue && !strobe.useLegacy && (issueGroup == GROUP_W'(g));
    always_ff @(posedge clk) begin
      if (rst)                grpCnt <= '0;
      else if (hit)           grpCnt <= cfgLong - CW'(1);
      else if (grpCnt != '0)  grpCnt <= grpCnt - CW'(1);
    end
    assign groupIdle[g] = (grpCnt == '0);
  end

  logic [LAT_W-1:0] rdLat;
  logic [LAT_W-1:0] wrLat;

  assign rdLat = {1'b0, cfgCasRd} + {1'b0, cfgBurst};
  assign wrLat = {1'b0, cfgCasWr} + {1'b0, cfgBurst};

  bgc_done_pipe #(.DEPTH(PIPE_DEPTH), .LAT_W(LAT_W)) rdPipe (
    .clk   (clk),
    .rst   (rst),
    .insert(strobe.issue && !strobe.isWrite),
    .lat   (rdLat),
    .pulse (rdDataValid)
  );

  bgc_done_pipe #(.DEPTH(PIPE_DEPTH), .LAT_W(LAT_W)) wrPipe (
    .clk   (clk),
    .rst   (rst),
    .insert(strobe.issue && strobe.isWrite),
    .lat   (wrLat),
    .pulse (wrDone)
  );

endmodule

// File: rtl/bg_col_gate.sv
module bg_col_gate
  import bgc_pkg::*;
#(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int CW              = 6,
  parameter int PREFETCH        = 8,
  parameter int WORDS_PER_CLK   = 2,
  parameter int ROW_CODE_W      = 2,
  localparam int BANK_W         = $clog2(NUM_GROUPS * BANKS_PER_GROUP)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  legacyMode,
  input  logic [CW-1:0]         cfgShort,
  input  logic [CW-1:0]         cfgLong,
  input  logic [CW-1:0]         cfgCasRd,
  input  logic [CW-1:0]         cfgCasWr,
  input  logic [CW-1:0]         cfgBurst,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [BANK_W-1:0]     reqBank,
  output logic                  reqReady,
  output logic                  cmdFire,
  output logic                  cmdWrite,
  output logic [BANK_W-1:0]     cmdBank,
  input  logic                  rowValid,
  input  logic [ROW_CODE_W-1:0] rowCode,
  output logic                  rowFire,
  output logic [ROW_CODE_W-1:0] rowCodeOut,
  output logic                  rdDataValid,
  output logic                  wrDone
);

  localparam int GROUP_W    = $clog2(NUM_GROUPS);
  localparam int LEGACY_CCD = PREFETCH / WORDS_PER_CLK;

  bgc_strobe_t           strobe;
  logic [GROUP_W-1:0]    reqGroup;
  logic                  globalIdle;
  logic [NUM_GROUPS-1:0] groupIdle;

  bgc_ctrl #(.NUM_GROUPS(NUM_GROUPS), .BANK_W(BANK_W), .GROUP_W(GROUP_W)) ctrl (
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqBank   (reqBank),
    .legacyMode(legacyMode),
    .globalIdle(globalIdle),
    .groupIdle (groupIdle),
    .reqReady  (reqReady),
    .reqGroup  (reqGroup),
    .strobe    (strobe)
  );

  bgc_datapath #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .CW(CW),
                 .LEGACY_CCD(LEGACY_CCD)) dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .issueGroup (reqGroup),
    .cfgShort   (cfgShort),
    .cfgLong    (cfgLong),
    .cfgCasRd   (cfgCasRd),
    .cfgCasWr   (cfgCasWr),
    .cfgBurst   (cfgBurst),
    .globalIdle (globalIdle),
    .groupIdle  (groupIdle),
    .rdDataValid(rdDataValid),
    .wrDone     (wrDone)
  );

  assign cmdFire  = strobe.issue;
  assign cmdWrite = reqWrite;
  assign cmdBank  = reqBank;

  // Row commands bypass the column spacing logic.
  assign rowFire    = rowValid;
  assign rowCodeOut = rowCode;

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int NUM_GROUPS = 4,
  parameter int BANK_W     = 4,
  parameter int CW         = 6,
  parameter int LEGACY_CCD = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              legacyMode,
  input logic [CW-1:0]     cfgShort,
  input logic [CW-1:0]     cfgLong,
  input logic              cmdFire,
  input logic [BANK_W-1:0] cmdBank,
  input logic              reqReady
);

  localparam int GROUP_W = $clog2(NUM_GROUPS);

  logic [CW:0]        sinceAny;
  logic [CW:0]        sinceGrp [NUM_GROUPS];
  logic [GROUP_W-1:0] fireGroup;

  assign fireGroup = cmdBank[BANK_W-1 -: GROUP_W];

  // Cycles since the last issue, saturating at all ones.
  always_ff @(posedge clk) begin
    if (rst)               sinceAny <= '1;
    else if (cmdFire)      sinceAny <= (CW+1)'(1);
    else if (sinceAny != '1) sinceAny <= sinceAny + (CW+1)'(1);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gSince
    always_ff @(posedge clk) begin
      if (rst)                                        sinceGrp[g] <= '1;
      else if (cmdFire && fireGroup == GROUP_W'(g))   sinceGrp[g] <= (CW+1)'(1);
      else if (sinceGrp[g] != '1)                     sinceGrp[g] <= sinceGrp[g] + (CW+1)'(1);
    end
  end

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> reqReady);

  p_min_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmdFire && !legacyMode) |-> (sinceAny >= {1'b0, cfgShort}));

  p_same_group_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (cmdFire && !legacyMode) |-> (sinceGrp[fireGroup] >= {1'b0, cfgLong}));

  p_legacy_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (cmdFire && legacyMode) |-> (sinceAny >= (CW+1)'(LEGACY_CCD)));

endmodule

bind bg_col_gate bgc_checker #(
  .NUM_GROUPS(NUM_GROUPS), .BANK_W(BANK_W), .CW(CW), .LEGACY_CCD(LEGACY_CCD)
) chk (
  .clk       (clk),
  .rst       (rst),
  .legacyMode(legacyMode),
  .cfgShort  (cfgShort),
  .cfgLong   (cfgLong),
  .cmdFire   (cmdFire),
  .cmdBank   (cmdBank),
  .reqReady  (reqReady)
);

// File: tb/bg_col_gate_test.sv
module bg_col_gate_test;

  localparam int CW = 6;
  localparam int S  = 2;
  localparam int L  = 5;
  localparam int CL = 9;
  localparam int CWL = 5;
  localparam int BL = 4;

  logic clk = 0;
  logic rst = 1;
  logic legacyMode = 0;
  logic [CW-1:0] cfgShort = CW'(S), cfgLong = CW'(L), cfgCasRd = CW'(CL),
                 cfgCasWr = CW'(CWL), cfgBurst = CW'(BL);
  logic reqValid = 0, reqWrite = 0;
  logic [3:0] reqBank = '0;
  logic reqReady, cmdFire, cmdWrite;
  logic [3:0] cmdBank;
  logic rowValid = 0;
  logic [1:0] rowCode = '0;
  logic rowFire;
  logic [1:0] rowCodeOut;
  logic rdDataValid, wrDone;

  bg_col_gate uut (.*);

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;
  bit sawBoth = 0;
  int rdQ[$];
  int wrQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: presents a request, waits for ready and records the expected completion.
  task automatic colReq(input bit w, input logic [3:0] b, output int grantCyc, output int reqCyc);
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqBank = b;
    #1;
    reqCyc = cyc;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    grantCyc = cyc;
    if (w) wrQ.push_back(cyc + CWL + BL);
    else   rdQ.push_back(cyc + CL + BL);
    @(posedge clk);
    #1 reqValid = 0;
  endtask

  // Monitor: compares each completion pulse with the head of its queue.
  always @(negedge clk) begin
    if (!rst) begin
      if (rdDataValid && wrDone) sawBoth = 1;
      if (rdDataValid) begin
        if (rdQ.size() == 0) check(0, "R6 unexpected read pulse", cyc, -1);
        else begin
          int e;
          e = rdQ.pop_front();
          check(cyc == e, "R6 read completion cycle", cyc, e);
        end
      end
      if (wrDone) begin
        if (wrQ.size() == 0) check(0, "R7 unexpected write pulse", cyc, -1);
        else begin
          int e;
          e = wrQ.pop_front();
          check(cyc == e, "R7 write completion cycle", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int g0, g1, g2, r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R1 reset state
    check(reqReady == 1, "R1 ready after reset", reqReady, 1);
    check(rdDataValid == 0 && wrDone == 0, "R1 no completion after reset", rdDataValid | wrDone, 0);
    colReq(0, 4'd0, g0, r);
    check(g0 == r, "R1 first request immediate", g0 - r, 0);

    // R2 different group at exactly cfgShort
    colReq(0, 4'd4, g1, r);
    check(g1 - g0 == S, "R2 different-group spacing", g1 - g0, S);
    // R3 same group at cfgLong
    colReq(1, 4'd5, g2, r);
    check(g2 - g1 == L, "R3 same-group spacing", g2 - g1, L);

    // R4 rotation across groups: one command per cfgShort
    g0 = g2;
    colReq(1, 4'd8, g1, r);
    check(g1 - g0 == S, "R4 rotation gap group2", g1 - g0, S);
    colReq(0, 4'd12, g2, r);
    check(g2 - g1 == S, "R4 rotation gap group3", g2 - g1, S);
    colReq(1, 4'd1, g0, r);
    check(g0 - g2 == S, "R4 rotation gap group0", g0 - g2, S);

    // R8 row command passes while column commands are held off
    @(negedge clk);
    rowValid = 1; rowCode = 2'd2;
    #1;
    check(reqReady == 0, "R8 column held during row test", reqReady, 0);
    check(rowFire == 1 && rowCodeOut == 2'd2, "R8 row passthrough", {rowFire, rowCodeOut}, 6);
    rowValid = 0;

    // R5 no slot grid
    repeat (9) @(negedge clk);
    colReq(0, 4'd2, g0, r);
    check(g0 == r, "R5 off-grid immediate grant", g0 - r, 0);

    // R6/R7 coincident completions: read then write four cycles later
    repeat (10) @(negedge clk);
    colReq(0, 4'd9, g0, r);
    repeat (3) @(negedge clk);
    colReq(1, 4'd13, g1, r);
    check(g1 - g0 == 4, "R7 write placed four cycles after read", g1 - g0, 4);
    repeat (20) @(negedge clk);
    check(sawBoth, "R6 R7 coincident read and write pulses", sawBoth, 1);

    // R9 legacy single spacing
    repeat (80) @(negedge clk);
    legacyMode = 1;
    colReq(0, 4'd0, g0, r);
    colReq(0, 4'd4, g1, r);
    check(g1 - g0 == 4, "R9 legacy different-group spacing", g1 - g0, 4);
    colReq(1, 4'd5, g2, r);
    check(g2 - g1 == 4, "R9 legacy same-group spacing", g2 - g1, 4);
    repeat (80) @(negedge clk);
    legacyMode = 0;

    repeat (30) @(negedge clk);
    check(rdQ.size() == 0, "R6 all reads completed", rdQ.size(), 0);
    check(wrQ.size() == 0, "R7 all writes completed", wrQ.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule